// File: doc/BRIEF.md
# Access-Count Row Closure Predictor

This block sits beside a DRAM memory controller and decides, bank by bank, when an open row should be precharged. It watches three kinds of event from the controller: row activations, column accesses and precharges. It learns how many column accesses each row tends to receive while it is open. When a row is opened again, that learned count tells the block when the row has served its purpose. After the access that reaches the count, the block raises a one-cycle close request for that bank.

History is kept in a small direct-mapped table. Each entry holds a valid bit, a partial row tag and a saturating access count. An entry is written when a row is precharged, using the number of column accesses the row received while it was open.

Rows with no usable entry fall back to a hybrid open/close policy. Each bank has a 2-bit confidence counter. Row hits push the counter toward keeping rows open, and precharges forced by a conflicting request push it toward closing rows after each access. The controller turns the close requests into precharge commands. It can hold a request back by flagging that a request to the same row is still waiting in its queue.

Top module: `row_close_predictor`

## Requirements
- R1: After reset, `close_req` is all zeros, every bank is treated as having no open row, every history entry is invalid and every bank's hybrid counter holds 2.
- R2: When a row was opened with a valid history entry holding count N ≥ 1, a close request for that bank appears in the cycle after the column access that brings the row's access count to N, and not earlier.
- R3: A history entry holding 0 or 1 (zero live time) makes the row's first column access raise the close request in the next cycle.
- R4: With no usable entry and a hybrid counter of 2 or 3 (open policy), the bank never raises a close request during that activation.
- R5: The hybrid counter rises by one, saturating at 3, on each column access that is not the first after activation. It falls by one, saturating at 0, on a precharge of an open row with `pre_conflict` high. With no usable entry and a counter of 0 or 1 at the time of the first column access, that access raises a close request in the next cycle.
- R6: The table index is `row[5:0] XOR (bank << 4)`. An entry is used only if it is valid and its tag equals `row[11:6]`. A row that shares an index with a different tag gets no prediction.
- R7: The per-row access count saturates at 15. A row that received more than 15 accesses is stored as 15, and its next activation requests closure after its fifteenth access.
- R8: At most one close request is raised per activation, and each request is high for exactly one cycle.
- R9: A close request is suppressed when `pend_same_row` for that bank is high in the cycle of the qualifying column access. The request then comes from the next column access to the row whose `pend_same_row` is low.
- R10: A column access to a bank with no open row produces no request and does not change the hybrid counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_valid | input | 1 | A row activation is issued this cycle |
| act_bank | input | BANK_W | Bank of the activation |
| act_row | input | ROW_W | Row being opened |
| col_valid | input | 1 | A column access is issued this cycle |
| col_bank | input | BANK_W | Bank of the column access |
| pre_valid | input | 1 | A precharge is issued this cycle |
| pre_bank | input | BANK_W | Bank being precharged |
| pre_conflict | input | 1 | The precharge was forced by a request to another row |
| pend_same_row | input | NUM_BANKS | Per bank: a queued request targets the currently open row |
| close_req | output | NUM_BANKS | Per bank one-cycle request to precharge the open row |

## Verification
The hardest state to reach is a bank whose hybrid counter has fallen into the close range. That state only arises after repeated conflict precharges, and the bank must then open a row with no table entry. The stimulus builds it by activating and conflict-precharging two fresh rows, which drives the counter from 2 to 0. It then opens a third fresh row and checks that the next hits raise the counter back to the open range. Saturation is reached by a long burst of column accesses before a precharge, and tag aliasing by reopening a row that shares an index with a stored one.

// File: rtl/rcp_pkg.sv
package rcp_pkg;

    // Per-bank hybrid policy confidence, ordered so that >= HYB_WEAK_OPEN means open policy.
    typedef enum logic [1:0] {
        HYB_STRONG_CLOSE = 2'd0,
        HYB_WEAK_CLOSE   = 2'd1,
        HYB_WEAK_OPEN    = 2'd2,
        HYB_STRONG_OPEN  = 2'd3
    } hyb_t;

    function automatic hyb_t hyb_up(input hyb_t h);
        return (h == HYB_STRONG_OPEN) ? h : hyb_t'(h + 2'd1);
    endfunction

    function automatic hyb_t hyb_down(input hyb_t h);
        return (h == HYB_STRONG_CLOSE) ? h : hyb_t'(h - 2'd1);
    endfunction

endpackage

// File: rtl/rcp_hist_table.sv
module rcp_hist_table #(
    parameter int DEPTH = 64,
    parameter int TAG_W = 6,
    parameter int CNT_W = 4,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             rd_hit,
    output logic [CNT_W-1:0] rd_cnt,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [CNT_W-1:0] wr_cnt
);

    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
        logic [CNT_W-1:0] cnt;
    } entry_t;

    entry_t tbl_d [DEPTH];
    entry_t tbl_q [DEPTH];

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en) begin
            tbl_d[wr_idx] = '{vld: 1'b1, tag: wr_tag, cnt: wr_cnt};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) tbl_q[i] <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    // Lookup reads registered contents; a write in the same cycle is seen next cycle.
    assign rd_hit = tbl_q[rd_idx].vld && (tbl_q[rd_idx].tag == rd_tag);
    assign rd_cnt = tbl_q[rd_idx].cnt;

endmodule

// File: rtl/rcp_bank_tracker.sv
module rcp_bank_tracker
    import rcp_pkg::*;
#(
    parameter int ROW_W = 12,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_i,
    input  logic [ROW_W-1:0] act_row_i,
    input  logic             lk_hit_i,
    input  logic [CNT_W-1:0] lk_cnt_i,
    input  logic             col_i,
    input  logic             pre_i,
    input  logic             pre_conflict_i,
    input  logic             pend_i,
    output logic             close_req_o,
    output logic             open_o,
    output logic [ROW_W-1:0] row_o,
    output logic [CNT_W-1:0] live_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic             open;
        logic [ROW_W-1:0] row;
        logic [CNT_W-1:0] live;
        logic             pred_vld;
        logic [CNT_W-1:0] pred_cnt;
        logic             armed;
        hyb_t             hyb;
        logic             req;
    } trk_t;

    trk_t st_d, st_q;

    logic [CNT_W-1:0] live_inc;
    logic [CNT_W-1:0] target;
    logic             reach;

    always_comb begin
        live_inc = (st_q.live == CNT_MAX) ? st_q.live : st_q.live + CNT_ONE;
        target   = (st_q.pred_cnt == '0) ? CNT_ONE : st_q.pred_cnt;
        reach    = st_q.pred_vld ? (live_inc >= target)
                                 : (st_q.hyb < HYB_WEAK_OPEN);

        st_d     = st_q;
        st_d.req = 1'b0;

        if (act_i) begin
            st_d.open     = 1'b1;
            st_d.row      = act_row_i;
            st_d.live     = '0;
            st_d.pred_vld = lk_hit_i;
            st_d.pred_cnt = lk_cnt_i;
            st_d.armed    = 1'b1;
        end else if (pre_i && st_q.open) begin
            st_d.open  = 1'b0;
            st_d.armed = 1'b0;
            if (pre_conflict_i) st_d.hyb = hyb_down(st_q.hyb);
        end else if (col_i && st_q.open) begin
            st_d.live = live_inc;
            if (st_q.live != '0) st_d.hyb = hyb_up(st_q.hyb);
            if (st_q.armed && reach && !pend_i) begin
                st_d.req   = 1'b1;
                st_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.hyb <= HYB_WEAK_OPEN;
        end else begin
            st_q <= st_d;
        end
    end

    assign close_req_o = st_q.req;
    assign open_o      = st_q.open;
    assign row_o       = st_q.row;
    assign live_o      = st_q.live;

endmodule

// File: rtl/row_close_predictor.sv
module row_close_predictor #(
    parameter int NUM_BANKS  = 4,
    parameter int ROW_W      = 12,
    parameter int HIST_DEPTH = 64,
    parameter int TAG_W      = 6,
    parameter int CNT_W      = 4,
    localparam int BANK_W    = $clog2(NUM_BANKS),
    localparam int IDX_W     = $clog2(HIST_DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 act_valid,
    input  logic [BANK_W-1:0]    act_bank,
    input  logic [ROW_W-1:0]     act_row,
    input  logic                 col_valid,
    input  logic [BANK_W-1:0]    col_bank,
    input  logic                 pre_valid,
    input  logic [BANK_W-1:0]    pre_bank,
    input  logic                 pre_conflict,
    input  logic [NUM_BANKS-1:0] pend_same_row,
    output logic [NUM_BANKS-1:0] close_req
);

    function automatic logic [IDX_W-1:0] hash_idx(input logic [BANK_W-1:0] b,
                                                  input logic [ROW_W-1:0]  r);
        return r[IDX_W-1:0] ^ {b, {(IDX_W-BANK_W){1'b0}}};
    endfunction

    function automatic logic [TAG_W-1:0] row_tag(input logic [ROW_W-1:0] r);
        return r[IDX_W +: TAG_W];
    endfunction

    logic             lk_hit;
    logic [CNT_W-1:0] lk_cnt;
    logic             wb_en;
    logic [IDX_W-1:0] wb_idx;
    logic [TAG_W-1:0] wb_tag;
    logic [CNT_W-1:0] wb_cnt;

    logic             trk_open [NUM_BANKS];
    logic [ROW_W-1:0] trk_row  [NUM_BANKS];
    logic [CNT_W-1:0] trk_live [NUM_BANKS];

    always_comb begin
        wb_en  = pre_valid && trk_open[pre_bank];
        wb_idx = hash_idx(pre_bank, trk_row[pre_bank]);
        wb_tag = row_tag(trk_row[pre_bank]);
        wb_cnt = trk_live[pre_bank];
    end

    rcp_hist_table #(
        .DEPTH (HIST_DEPTH),
        .TAG_W (TAG_W),
        .CNT_W (CNT_W)
    ) i_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (hash_idx(act_bank, act_row)),
        .rd_tag (row_tag(act_row)),
        .rd_hit (lk_hit),
        .rd_cnt (lk_cnt),
        .wr_en  (wb_en),
        .wr_idx (wb_idx),
        .wr_tag (wb_tag),
        .wr_cnt (wb_cnt)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        rcp_bank_tracker #(
            .ROW_W (ROW_W),
            .CNT_W (CNT_W)
        ) i_trk (
            .clk            (clk),
            .rst_n          (rst_n),
            .act_i          (act_valid && (act_bank == BANK_W'(g))),
            .act_row_i      (act_row),
            .lk_hit_i       (lk_hit),
            .lk_cnt_i       (lk_cnt),
            .col_i          (col_valid && (col_bank == BANK_W'(g))),
            .pre_i          (pre_valid && (pre_bank == BANK_W'(g))),
            .pre_conflict_i (pre_conflict),
            .pend_i         (pend_same_row[g]),
            .close_req_o    (close_req[g]),
            .open_o         (trk_open[g]),
            .row_o          (trk_row[g]),
            .live_o         (trk_live[g])
        );
    end

endmodule

// File: rtl/rcp_checker.sv
module rcp_checker #(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 col_valid,
    input logic [BANK_W-1:0]    col_bank,
    input logic [NUM_BANKS-1:0] pend_same_row,
    input logic [NUM_BANKS-1:0] close_req
);

    // R8
    one_bank_per_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(close_req));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
        // R8
        single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            close_req[b] |=> !close_req[b]);

        // R2
        req_follows_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
            close_req[b] |-> $past(col_valid && (col_bank == BANK_W'(b))));

        // R9
        pend_suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(col_valid && (col_bank == BANK_W'(b)) && pend_same_row[b]) |-> !close_req[b]);
    end

endmodule

bind row_close_predictor rcp_checker #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W)
) i_rcp_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .col_valid     (col_valid),
    .col_bank      (col_bank),
    .pend_same_row (pend_same_row),
    .close_req     (close_req)
);

// File: tb/test_row_close_predictor.sv
`timescale 1ns/1ps
module test_row_close_predictor;

    localparam int NB = 4;
    localparam int BW = 2;
    localparam int RW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          act_valid = 1'b0;
    logic [BW-1:0] act_bank = '0;
    logic [RW-1:0] act_row = '0;
    logic          col_valid = 1'b0;
    logic [BW-1:0] col_bank = '0;
    logic          pre_valid = 1'b0;
    logic [BW-1:0] pre_bank = '0;
    logic          pre_conflict = 1'b0;
    logic [NB-1:0] pend_same_row = '0;
    logic [NB-1:0] close_req;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic [NB-1:0] exp;
        string         tag;
    } item_t;
    item_t sb_q[$];

    always #2.5 clk = ~clk;

    row_close_predictor i_row_close_predictor (
        .clk           (clk),
        .rst_n         (rst_n),
        .act_valid     (act_valid),
        .act_bank      (act_bank),
        .act_row       (act_row),
        .col_valid     (col_valid),
        .col_bank      (col_bank),
        .pre_valid     (pre_valid),
        .pre_bank      (pre_bank),
        .pre_conflict  (pre_conflict),
        .pend_same_row (pend_same_row),
        .close_req     (close_req)
    );

    // Monitor: after each rising edge, compare the output against the queued expectation.
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_tests++;
            if (close_req !== it.exp) begin
                n_fail++;
                $display("FAIL %s: close_req=%b expected %b", it.tag, close_req, it.exp);
            end
        end
    end

    task automatic clear_inputs();
        act_valid = 1'b0; col_valid = 1'b0; pre_valid = 1'b0;
        pre_conflict = 1'b0; pend_same_row = '0;
    endtask

    task automatic push(input logic [NB-1:0] exp, input string tag);
        item_t it;
        it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic idle(input string tag);
        @(negedge clk); clear_inputs(); push('0, tag);
    endtask

    task automatic do_act(input int b, input int row, input string tag);
        @(negedge clk); clear_inputs();
        act_valid = 1'b1; act_bank = BW'(b); act_row = RW'(row);
        push('0, tag);
    endtask

    task automatic do_pre(input int b, input bit conf, input string tag);
        @(negedge clk); clear_inputs();
        pre_valid = 1'b1; pre_bank = BW'(b); pre_conflict = conf;
        push('0, tag);
    endtask

    task automatic do_col(input int b, input bit pend, input bit exp_req, input string tag);
        logic [NB-1:0] e;
        @(negedge clk); clear_inputs();
        col_valid = 1'b1; col_bank = BW'(b);
        pend_same_row[b] = pend;
        e = '0; e[b] = exp_req;
        push(e, tag);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        idle("R1 reset idle");
        idle("R1 reset idle");

        // R4: bank0 row5 has no history, counter at 2 -> open policy.
        do_act(0, 5, "R4 act");
        do_col(0, 0, 0, "R4 first col");
        do_col(0, 0, 0, "R4 hit");
        do_col(0, 0, 0, "R4 hit");
        do_pre(0, 0, "R2 store 3");
        // R2: learned count 3.
        do_act(0, 5, "R2 reopen");
        do_col(0, 0, 0, "R2 access 1");
        do_col(0, 0, 0, "R2 access 2");
        do_col(0, 0, 1, "R2 access 3 reaches count");
        do_col(0, 0, 0, "R8 no second request");
        do_pre(0, 0, "R2 close");

        // R3: zero live time, count 1.
        do_act(1, 9, "R3 act");
        do_col(1, 0, 0, "R3 learn pass");
        do_pre(1, 0, "R3 store 1");
        do_act(1, 9, "R3 reopen");
        do_col(1, 0, 1, "R3 first access closes");
        do_pre(1, 0, "R3 close");
        // R3: stored count 0.
        do_act(1, 200, "R3 act no col");
        do_pre(1, 0, "R3 store 0");
        do_act(1, 200, "R3 reopen count0");
        do_col(1, 0, 1, "R3 count0 closes after first");
        do_pre(1, 0, "R3 close");
        // R6: same index, different tag.
        do_act(1, 73, "R6 alias act");
        do_col(1, 0, 0, "R6 tag mismatch no prediction");
        do_col(1, 0, 0, "R6 tag mismatch no prediction");
        do_pre(1, 0, "R6 close");

        // R5 / R10: drive bank2 counter to close range.
        do_act(2, 10, "R5 act");
        do_pre(2, 1, "R5 conflict");
        do_act(2, 11, "R5 act");
        do_pre(2, 1, "R5 conflict");
        do_col(2, 0, 0, "R10 col to closed bank");
        do_act(2, 12, "R5 act fresh row");
        do_col(2, 0, 1, "R5 close policy request");
        do_col(2, 0, 0, "R8 one per activation");
        do_col(2, 0, 0, "R5 hit raises counter");
        do_pre(2, 0, "R5 close");
        do_act(2, 13, "R5 act fresh row");
        do_col(2, 0, 0, "R5 counter back in open range");
        do_pre(2, 0, "R5 close");

        // R9: suppression by pending same-row request.
        do_act(3, 7, "R9 act");
        do_col(3, 0, 0, "R9 learn pass");
        do_pre(3, 0, "R9 store 1");
        do_act(3, 7, "R9 reopen");
        do_col(3, 1, 0, "R9 suppressed by pending");
        do_col(3, 0, 1, "R9 request on next access");
        do_pre(3, 0, "R9 close");

        // R7: saturation at 15.
        do_act(0, 100, "R7 act");
        for (int i = 0; i < 20; i++) do_col(0, 0, 0, "R7 long burst");
        do_pre(0, 0, "R7 store saturated");
        do_act(0, 100, "R7 reopen");
        for (int i = 0; i < 14; i++) do_col(0, 0, 0, "R7 below 15");
        do_col(0, 0, 1, "R7 fifteenth access");
        idle("R8 pulse ends");
        idle("R8 idle");

        @(negedge clk); clear_inputs();
        repeat (3) @(posedge clk);
        #2;
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule